// File: doc/BRIEF.md
# Three-Operand Interlock Collapsing ALU

This block is a 32-bit two's complement ALU that takes three operands and returns one result. Its purpose is to let a dependent instruction pair run as a single fused operation. The first operation combines A and B. The second operation then combines that intermediate value with C.

The result is always the same as running the two operations one after the other, with 32-bit wraparound. Arithmetic supports add and subtract. Logic supports AND, OR, XOR and pass, each with an optional complement. That gives four fused categories:

- A±B±C
- (A lop B)±C
- (A±B) lop C
- (A lop B) lop C

A non-interlocked two-operand operation is run through the same path with C forced to zero. It needs no extra hardware.

The datapath has four stages in order:

1. a bitwise logic stage ahead of the adder,
2. a 3-to-2 carry-save stage,
3. a carry-lookahead adder made of four 8-bit groups,
4. a bitwise logic stage after the adder that combines the adder output with C.

The whole path from operands to result is combinational. The result and a zero flag are captured in one output register on every clock edge.

Top module: `icalu3_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes 0 and `result_zero` becomes 1.
- R2: With `fuse_en`=1 and both op codes arithmetic (bit 3 = 0; bit 0 = 1 means subtract, 0 means add), `result` after the next rising edge equals (A ± B) ± C modulo 2^32.
- R3: With `fuse_en`=1, a logic first op (bit 3 = 1) and an arithmetic second op, `result` equals (A lop B) ± C modulo 2^32. The logic function is picked by bits [1:0]: 00 AND, 01 OR, 10 XOR, 11 pass-left.
- R4: With `fuse_en`=1, an arithmetic first op and a logic second op, `result` equals (A ± B) lop C.
- R5: With `fuse_en`=1 and both ops logic, `result` equals (A lop B) lop C.
- R6: With `fuse_en`=0, `result` equals A op_first B. Both `opnd_c` and `op_second` have no effect.
- R7: For a logic op code, bit 2 complements that stage's output (giving NAND, NOR, XNOR, NOT). For an arithmetic op code, bits 2 and 1 are ignored.
- R8: The carry out of bit 31 is discarded, so sums and differences wrap (0x7FFFFFFF+1+1 = 0x80000001, 0x80000000−1−1 = 0x7FFFFFFE).
- R9: `result_zero` is 1 exactly when the registered `result` is 0, and it updates on the same edge as `result`.
- R10: Operands present at a rising edge determine `result` right after that edge (one-cycle latency, no hold between edges).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fuse_en | input | 1 | 1: interlocked (three-operand) mode; 0: C forced to zero, second op ignored |
| op_first | input | 4 | Op code applied to A and B |
| op_second | input | 4 | Op code applied to the first result and C |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| opnd_c | input | 32 | Operand C |
| result | output | 32 | Registered fused result |
| result_zero | output | 1 | Registered flag, 1 when result is zero |

## Verification
Most internal faults show up at the ports in the very next cycle, because no state is held between operations.

| Internal fault | What appears at `result` |
|---|---|
| Wrong subtract increment placement | Off by one, but only on subtract codes |
| Lost carry between lookahead groups | Error at bit 8, 16 or 24, only when a carry must cross that group edge |
| Wrong one-hot select | Wrong bitwise function for that op code |

For these reasons the vectors include carry chains that cross every group boundary, both subtract increments at once, and every logic function with and without complement.

// File: rtl/icalu3_pkg.sv
// Package: shared widths, op code fields and the decoded control word.
// Assumes op codes are 4 bits: [3] logic class, [2] complement, [1:0] function.
package icalu3_pkg;

    localparam int unsigned OP_W = 4;

    // One-hot select for a bitwise stage: [0] pass, [1] AND, [2] OR, [3] XOR.
    localparam logic [3:0] SEL_PASS = 4'b0001;
    localparam logic [3:0] SEL_AND  = 4'b0010;
    localparam logic [3:0] SEL_OR   = 4'b0100;
    localparam logic [3:0] SEL_XOR  = 4'b1000;

    typedef struct packed {
        logic [3:0] pre_sel;    // function of the pre-adder logic stage
        logic       pre_inv;    // complement pre-adder output
        logic       b_to_sum;   // B enters the carry-save stage
        logic       neg_b;      // B is subtracted
        logic       c_to_sum;   // C enters the carry-save stage
        logic       neg_c;      // C is subtracted
        logic [3:0] post_sel;   // function of the post-adder logic stage
        logic       post_inv;   // complement post-adder output
    } ctrl_t;

    // Map a logic function code to the stage one-hot select.
    function automatic logic [3:0] func_to_sel(input logic [1:0] f);
        case (f)
            2'b00:   func_to_sel = SEL_AND;
            2'b01:   func_to_sel = SEL_OR;
            2'b10:   func_to_sel = SEL_XOR;
            default: func_to_sel = SEL_PASS;
        endcase
    endfunction

endpackage

// File: rtl/icalu3_decode.sv
// Control decode: turns the mode bit and two op codes into per-stage selects.
// Assumes op code layout from icalu3_pkg. When fusing is off, the second op
// is replaced by "add C" and C is gated to zero, so only A op B remains.
module icalu3_decode
    import icalu3_pkg::*;
(
    input  logic            fuse_en,
    input  logic [OP_W-1:0] op_first,
    input  logic [OP_W-1:0] op_second,
    output ctrl_t           ctrl
);

    logic first_is_logic;
    logic second_is_logic;

    assign first_is_logic  = op_first[3];
    assign second_is_logic = fuse_en & op_second[3];

    // Build the control word for all four stages.
    always_comb begin
        ctrl          = '0;
        ctrl.pre_sel  = first_is_logic ? func_to_sel(op_first[1:0]) : SEL_PASS;
        ctrl.pre_inv  = first_is_logic & op_first[2];
        ctrl.b_to_sum = ~first_is_logic;
        ctrl.neg_b    = ~first_is_logic & op_first[0];
        ctrl.c_to_sum = fuse_en & ~op_second[3];
        ctrl.neg_c    = fuse_en & ~op_second[3] & op_second[0];
        ctrl.post_sel = second_is_logic ? func_to_sel(op_second[1:0]) : SEL_PASS;
        ctrl.post_inv = second_is_logic & op_second[2];
    end

    // R6: with fusing off, C never reaches the adder and the post stage passes.
    always_comb begin
        if (!fuse_en) begin
            p_nofuse_isolates_c_r6: assert (!ctrl.c_to_sum && ctrl.post_sel == SEL_PASS && !ctrl.post_inv);
        end
    end

endmodule

// File: rtl/icalu3_bitlogic.sv
// Bitwise logic stage: pass, AND, OR or XOR of two words, optional complement.
// Assumes a one-hot (or all-zero, giving zero) select.
module icalu3_bitlogic #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [3:0]   sel,
    input  logic         inv,
    output logic [W-1:0] out
);

    logic [W-1:0] raw;

    // Select the bitwise function.
    always_comb begin
        raw = ({W{sel[0]}} & lhs)
            | ({W{sel[1]}} & (lhs & rhs))
            | ({W{sel[2]}} & (lhs | rhs))
            | ({W{sel[3]}} & (lhs ^ rhs));
    end

    // Apply the optional complement.
    assign out = inv ? ~raw : raw;

    // R7: select must be one-hot so exactly one function is chosen.
    always_comb begin
        p_sel_onehot_r7: assert ($onehot0(sel));
    end

endmodule

// File: rtl/icalu3_csa.sv
// 3-to-2 carry-save stage. The carry vector is shifted left one place; its
// free bit 0 is filled from inc0, and the carry out of the top bit is dropped.
module icalu3_csa #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    input  logic         inc0,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] cry_v
);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Per-bit sum.
            assign sum_v[i] = x[i] ^ y[i] ^ z[i];
            if (i < W - 1) begin : g_cy
                // Per-bit majority carry into the next position.
                assign cry_v[i+1] = (x[i] & y[i]) | (y[i] & z[i]) | (x[i] & z[i]);
            end
        end
    endgenerate

    assign cry_v[0] = inc0;

    // R2/R8: the two vectors carry the same total modulo 2^W as the inputs.
    always_comb begin
        p_csa_keeps_total_r2: assert (W'(sum_v + cry_v) == W'(x + y + z + {{(W-1){1'b0}}, inc0}));
    end

endmodule

// File: rtl/icalu3_cla8.sv
// One carry-lookahead group: local generate/propagate, in-group carries,
// sum bits, and group generate/propagate for the level above.
module icalu3_cla8 #(
    parameter int unsigned GW = 8
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          cin,
    output logic [GW-1:0] sum,
    output logic          grp_g,
    output logic          grp_p
);

    logic [GW-1:0] g;
    logic [GW-1:0] p;
    logic [GW:0]   c;

    assign g    = a & b;
    assign p    = a ^ b;
    assign c[0] = cin;

    genvar i;
    generate
        for (i = 0; i < GW; i++) begin : g_car
            // In-group carry from generate/propagate.
            assign c[i+1] = g[i] | (p[i] & c[i]);
        end
    endgenerate

    assign sum = p ^ c[GW-1:0];

    // Group terms, independent of cin.
    always_comb begin
        grp_p = &p;
        grp_g = 1'b0;
        for (int k = 0; k < GW; k++) begin
            grp_g = g[k] | (p[k] & grp_g);
        end
    end

endmodule

// File: rtl/icalu3_cla.sv
// Two-input adder of NGRP lookahead groups. Only the lowest group sees the
// external carry-in; the rest take carries from group generate/propagate.
// The carry out of the top group is dropped (two's complement wraparound).
module icalu3_cla #(
    parameter int unsigned W  = 32,
    parameter int unsigned GW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);

    localparam int unsigned NGRP = W / GW;

    logic [NGRP-1:0] gg;
    logic [NGRP-1:0] gp;
    logic [NGRP-1:0] gc;

    assign gc[0] = cin;

    genvar j;
    generate
        for (j = 0; j < NGRP; j++) begin : g_grp
            icalu3_cla8 #(.GW(GW)) u_grp (
                .a     (a[j*GW +: GW]),
                .b     (b[j*GW +: GW]),
                .cin   (gc[j]),
                .sum   (sum[j*GW +: GW]),
                .grp_g (gg[j]),
                .grp_p (gp[j])
            );
            if (j < NGRP - 1) begin : g_link
                // Group carry from the level below.
                assign gc[j+1] = gg[j] | (gp[j] & gc[j]);
            end
        end
    endgenerate

    // R8: sum matches a plain wrapping add.
    always_comb begin
        p_cla_wraps_r8: assert (sum == W'(a + b + {{(W-1){1'b0}}, cin}));
    end

endmodule

// File: rtl/icalu3_top.sv
// Three-operand interlock collapsing ALU. A combinational path of
// pre-logic, carry-save, lookahead adder and post-logic computes
// (A op1 B) op2 C; the value and a zero flag are registered each edge.
// Assumes synchronous active-low reset and 32-bit two's complement data.
module icalu3_top
    import icalu3_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned GW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fuse_en,
    input  logic [OP_W-1:0] op_first,
    input  logic [OP_W-1:0] op_second,
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [W-1:0]    opnd_c,
    output logic [W-1:0]    result,
    output logic            result_zero
);

    ctrl_t        ctrl;
    logic [W-1:0] pre_out;
    logic [W-1:0] y_in;
    logic [W-1:0] z_in;
    logic [W-1:0] sum_v;
    logic [W-1:0] cry_v;
    logic [W-1:0] add_out;
    logic [W-1:0] post_out;

    icalu3_decode u_dec (
        .fuse_en   (fuse_en),
        .op_first  (op_first),
        .op_second (op_second),
        .ctrl      (ctrl)
    );

    icalu3_bitlogic #(.W(W)) u_pre (
        .lhs (opnd_a),
        .rhs (opnd_b),
        .sel (ctrl.pre_sel),
        .inv (ctrl.pre_inv),
        .out (pre_out)
    );

    // Operand conditioning for the carry-save stage (invert for subtract).
    always_comb begin
        y_in = ctrl.b_to_sum ? (ctrl.neg_b ? ~opnd_b : opnd_b) : '0;
        z_in = ctrl.c_to_sum ? (ctrl.neg_c ? ~opnd_c : opnd_c) : '0;
    end

    icalu3_csa #(.W(W)) u_csa (
        .x     (pre_out),
        .y     (y_in),
        .z     (z_in),
        .inc0  (ctrl.neg_b),
        .sum_v (sum_v),
        .cry_v (cry_v)
    );

    icalu3_cla #(.W(W), .GW(GW)) u_add (
        .a   (sum_v),
        .b   (cry_v),
        .cin (ctrl.neg_c),
        .sum (add_out)
    );

    icalu3_bitlogic #(.W(W)) u_post (
        .lhs (add_out),
        .rhs (opnd_c),
        .sel (ctrl.post_sel),
        .inv (ctrl.post_inv),
        .out (post_out)
    );

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            result_zero <= 1'b1;
        end else begin
            result      <= post_out;
            result_zero <= (post_out == '0);
        end
    end

    // R9: flag agrees with the registered result.
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        result_zero == (result == '0));

    // R2/R10: a fused three-way add lands one edge later.
    p_add3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_en && op_first == 4'b0000 && op_second == 4'b0000)
        |=> result == W'($past(opnd_a) + $past(opnd_b) + $past(opnd_c)));

    // R5: fused XOR then XOR.
    p_xor3_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_en && op_first == 4'b1010 && op_second == 4'b1010)
        |=> result == ($past(opnd_a) ^ $past(opnd_b) ^ $past(opnd_c)));

    // R6: without fusing, a subtract ignores C entirely.
    p_nofuse_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fuse_en && op_first == 4'b0001)
        |=> result == W'($past(opnd_a) - $past(opnd_b)));

endmodule

// File: tb/icalu3_top_test.sv
`timescale 1ns/1ps
module icalu3_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fuse_en = 1'b0;
    logic [3:0]  op_first = '0;
    logic [3:0]  op_second = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] opnd_c = '0;
    logic [31:0] result;
    logic        result_zero;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    icalu3_top uut (
        .clk(clk), .rst_n(rst_n), .fuse_en(fuse_en),
        .op_first(op_first), .op_second(op_second),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .result(result), .result_zero(result_zero)
    );

    // Reference logic function from the R3 encoding, complement per R7.
    function automatic logic [31:0] ref_lop(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] r;
        case (op[1:0])
            2'b00:   r = x & y;
            2'b01:   r = x | y;
            2'b10:   r = x ^ y;
            default: r = x;
        endcase
        return op[2] ? ~r : r;
    endfunction

    function automatic logic [31:0] ref_step(input logic [3:0] op, input logic [31:0] x, input logic [31:0] y);
        if (op[3]) return ref_lop(op, x, y);
        return op[0] ? x - y : x + y;
    endfunction

    function automatic logic [31:0] ref_all(input logic f, input logic [3:0] o1, input logic [3:0] o2,
                                            input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        logic [31:0] r1;
        r1 = ref_step(o1, a, b);
        return f ? ref_step(o2, r1, c) : r1;
    endfunction

    // Driver: apply one vector at the falling edge and queue its expectation.
    task automatic drive(input string tag, input logic f, input logic [3:0] o1, input logic [3:0] o2,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        item_t it;
        @(negedge clk);
        fuse_en = f; op_first = o1; op_second = o2;
        opnd_a = a; opnd_b = b; opnd_c = c;
        it.exp = ref_all(f, o1, o2, a, b, c);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Same as drive but with an explicit expected value for the corner cases.
    task automatic drive_exp(input string tag, input logic f, input logic [3:0] o1, input logic [3:0] o2,
                             input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                             input logic [31:0] e);
        item_t it;
        @(negedge clk);
        fuse_en = f; op_first = o1; op_second = o2;
        opnd_a = a; opnd_b = b; opnd_c = c;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare after each rising edge, away from the edge (R10, R9).
    always @(posedge clk) begin
        #5;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            applied++;
            if (result !== it.exp) begin
                bad++;
                $display("FAIL %s result=%h expected=%h", it.tag, result, it.exp);
            end
            if (result_zero !== (it.exp == 32'h0)) begin
                bad++;
                $display("FAIL R9 result_zero=%b expected=%b", result_zero, it.exp == 32'h0);
            end
        end
    end

    initial begin
        // R1: reset clears result and sets the zero flag, even with busy inputs.
        opnd_a = 32'h1234_5678; opnd_b = 32'h1111_1111; opnd_c = 32'h9;
        fuse_en = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        applied++;
        if (result !== 32'h0 || result_zero !== 1'b1) begin
            bad++;
            $display("FAIL R1 result=%h zero=%b expected=00000000 1", result, result_zero);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: arithmetic then arithmetic.
        drive("R2 add add", 1, 4'h0, 4'h0, 32'd3, 32'd4, 32'd5);
        drive("R2 sub add", 1, 4'h1, 4'h0, 32'd100, 32'd30, 32'd7);
        drive("R2 add sub", 1, 4'h0, 4'h1, 32'd10, 32'd20, 32'd50);
        drive("R2 sub sub", 1, 4'h1, 4'h1, 32'h0, 32'h0, 32'h0);
        drive("R2 carry chain", 1, 4'h0, 4'h0, 32'h00FF_FFFF, 32'h0000_0001, 32'h00FF_FF00);
        // R8: wraparound corner cases.
        drive_exp("R8 max+1+1", 1, 4'h0, 4'h0, 32'h7FFF_FFFF, 32'h1, 32'h1, 32'h8000_0001);
        drive_exp("R8 min-1-1", 1, 4'h1, 4'h1, 32'h8000_0000, 32'h1, 32'h1, 32'h7FFF_FFFE);
        drive_exp("R8 all ones+1", 1, 4'h0, 4'h0, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0);
        // R3: logic then arithmetic.
        drive("R3 and add", 1, 4'h8, 4'h0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0000_0101);
        drive("R3 or sub", 1, 4'h9, 4'h1, 32'h0000_00F0, 32'h0000_000F, 32'h0000_0100);
        drive("R3 xnor add", 1, 4'hE, 4'h0, 32'hAAAA_5555, 32'h5555_5555, 32'h1);
        // R4: arithmetic then logic.
        drive("R4 add xor", 1, 4'h0, 4'hA, 32'h1234_0000, 32'h0000_5678, 32'hFFFF_0000);
        drive("R4 sub nand", 1, 4'h1, 4'hC, 32'h10, 32'h1, 32'h0F);
        drive("R4 add pass", 1, 4'h0, 4'hB, 32'h7, 32'h8, 32'hDEAD_BEEF);
        // R5: logic then logic.
        drive("R5 and or", 1, 4'h8, 4'h9, 32'hFF00_0000, 32'h0F00_0000, 32'h0000_00FF);
        drive("R5 xor xor", 1, 4'hA, 4'hA, 32'h1357_9BDF, 32'h2468_ACE0, 32'hFFFF_FFFF);
        drive("R5 nor not", 1, 4'hD, 4'hF, 32'h0, 32'h0, 32'h0);
        // R6: non-interlocked mode, C and second op have no effect.
        drive_exp("R6 add ignores C", 0, 4'h0, 4'h1, 32'd40, 32'd2, 32'hFFFF_FFFF, 32'd42);
        drive_exp("R6 sub ignores C", 0, 4'h1, 4'hA, 32'd40, 32'd2, 32'h1234_5678, 32'd38);
        drive_exp("R6 and ignores C", 0, 4'h8, 4'hD, 32'hF0F0, 32'hFF00, 32'hFFFF_FFFF, 32'hF000);
        // R7: complement bit on logic; ignored on arithmetic codes.
        drive_exp("R7 nand first", 0, 4'hC, 4'h0, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0, 32'hFFFF_0000);
        drive_exp("R7 inv ignored on add", 1, 4'h4, 4'h6, 32'd1, 32'd2, 32'd3, 32'd6);
        drive_exp("R7 bit1 ignored on sub", 1, 4'h3, 4'h0, 32'd9, 32'd4, 32'd1, 32'd6);
        // R9: zero flag on a non-trivial zero result.
        drive_exp("R9 five-two-three", 1, 4'h1, 4'h1, 32'd5, 32'd2, 32'd3, 32'd0);
        drive_exp("R9 equal sub", 0, 4'h1, 4'h0, 32'hCAFE_F00D, 32'hCAFE_F00D, 32'h1, 32'd0);
        // R10: back-to-back random vectors across all codes and modes.
        for (int n = 0; n < 300; n++) begin
            drive("R10 random", 1'($urandom), 4'($urandom), 4'($urandom),
                  $urandom, $urandom, $urandom);
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

endmodule